// File: doc/BRIEF.md
# Sampled ADC Capture FIFO

This block collects 8-bit samples from an external successive-approximation converter and holds them in a 64-entry first-in first-out buffer. A host CPU drains the buffer through a byte-wide I/O port. A free-running divider, reloaded from a programmable rate value, produces a conversion tick. On a tick, and only while the buffer has room and no conversion is outstanding, the block raises the converter's chip-select with read/conversion mode and issues a one-cycle start strobe, which stands in for the dummy read that begins sampling.

When the converter reports that it is done, the block takes the data byte in that cycle, pushes it into the buffer and drops chip-select. The host reads a data port that pops one byte, or returns zero when nothing is held. A status port shows in bit 0 whether data is present. Any write to the status port empties the buffer.

Top module: `adc_capture_fifo`

## Requirements
- R1: After synchronous reset the buffer is empty (status reads 0x00, data reads 0x00), chip-select, read-mode and start are low, and the divider is loaded from `rate_div`.
- R2: While the converter answers promptly and the buffer is not full, start strobes come exactly `rate_div`+1 clock cycles apart.
- R3: A start strobe lasts one cycle and coincides with the rise of chip-select and read-mode, which stay high until the converter reports done.
- R4: A done indication while a conversion is outstanding pushes `cnv_data` into the buffer and chip-select is low in the following cycle.
- R5: Ticks that arrive while a conversion is outstanding produce no start strobe.
- R6: No conversion starts while the buffer holds 64 entries; starts resume once space is freed.
- R7: A read of port 0x04E7 returns the oldest byte and removes it, in arrival order; on an empty buffer it returns 0x00 and changes nothing.
- R8: A read of port 0x04E8 returns 0x01 when the buffer holds data and 0x00 when empty.
- R9: Any write to port 0x04E8, whatever its data, empties the buffer.
- R10: A host pop and a converter push in the same cycle both complete: the popped byte is the old head and the pushed byte stays held.
- R11: A done indication while no conversion is outstanding adds nothing to the buffer.
- R12: Writes to the data port and accesses to other addresses leave the buffer unchanged; reads elsewhere return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_div | input | 16 | Divider reload value; tick period is this plus one cycles |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host read strobe (one cycle per access) |
| io_wr | input | 1 | Host write strobe (one cycle per access) |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid in the cycle of the read strobe |
| cnv_cs | output | 1 | Converter chip-select, high while a conversion is outstanding |
| cnv_rdmode | output | 1 | Converter read/conversion mode select |
| cnv_start | output | 1 | One-cycle strobe that begins a conversion |
| cnv_done | input | 1 | Converter conversion-complete indication |
| cnv_data | input | 8 | Converter output byte, valid with `cnv_done` |

## Verification
The two functions that can meet in one cycle are a host pop of the data port and a converter completion pushing a new byte. The bench holds one byte in the buffer with a conversion pending, then raises `cnv_done` and the data-port read strobe on the same clock. It judges the outcome by the byte returned in that cycle being the old head, the status flag staying at 0x01 afterwards, and the next read returning the byte the converter delivered, followed by an empty status.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [0:0] {
        CONV_IDLE = 1'b0,
        CONV_BUSY = 1'b1
    } conv_state_e;

    typedef struct packed {
        logic sel_data;
        logic sel_stat;
    } port_sel_t;

    typedef struct packed {
        logic pop;
        logic flush;
    } host_op_t;

    function automatic port_sel_t decode_port(
        input logic [ADDR_W-1:0] addr,
        input logic [ADDR_W-1:0] data_port,
        input logic [ADDR_W-1:0] stat_port
    );
        port_sel_t s;
        s.sel_data = (addr == data_port);
        s.sel_stat = (addr == stat_port);
        return s;
    endfunction

endpackage

// File: rtl/adc_rate_tick.sv
module adc_rate_tick #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] reload_val,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= reload_val;
        end else if (cnt_q == '0) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = (cnt_q == '0);

    // R2
    tick_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && reload_val != '0) |=> !tick);

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_cap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              fifo_full,
    input  logic              cnv_done,
    input  logic [DATA_W-1:0] cnv_data,
    output logic              cnv_cs,
    output logic              cnv_rdmode,
    output logic              cnv_start,
    output logic              push,
    output logic [DATA_W-1:0] push_data
);
    conv_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CONV_IDLE;
            cnv_cs     <= 1'b0;
            cnv_rdmode <= 1'b0;
            cnv_start  <= 1'b0;
        end else begin
            cnv_start <= 1'b0;
            case (state_q)
                CONV_IDLE: begin
                    if (tick && !fifo_full) begin
                        state_q    <= CONV_BUSY;
                        cnv_cs     <= 1'b1;
                        cnv_rdmode <= 1'b1;
                        cnv_start  <= 1'b1;
                    end
                end
                CONV_BUSY: begin
                    if (cnv_done) begin
                        state_q    <= CONV_IDLE;
                        cnv_cs     <= 1'b0;
                        cnv_rdmode <= 1'b0;
                    end
                end
                default: state_q <= CONV_IDLE;
            endcase
        end
    end

    assign push      = (state_q == CONV_BUSY) && cnv_done;
    assign push_data = cnv_data;

    // R3
    start_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
        cnv_start |-> (cnv_cs && cnv_rdmode));

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        cnv_start |=> !cnv_start);

    // R5
    single_conv_chk: assert property (@(posedge clk) disable iff (rst)
        (cnv_cs && !cnv_done) |=> (cnv_cs && !cnv_start));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (cnv_cs && cnv_done) |=> !cnv_cs);

    // R6
    full_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full |=> !$rose(cnv_cs));

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count_q == '0);
    assign full    = (count_q == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= step(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= step(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL_CNT);

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

    // R10
    pop_push_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (do_push && do_pop && !flush) |=> $stable(count_q));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/adc_capture_fifo.sv
module adc_capture_fifo
    import adc_cap_pkg::*;
#(
    parameter int                DEPTH     = 64,
    parameter int                DATA_W    = 8,
    parameter int                RATE_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h04E7,
    parameter logic [ADDR_W-1:0] STAT_PORT = 16'h04E8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_div,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              cnv_cs,
    output logic              cnv_rdmode,
    output logic              cnv_start,
    input  logic              cnv_done,
    input  logic [DATA_W-1:0] cnv_data
);
    port_sel_t         sel;
    host_op_t          op;
    logic              tick;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic [DATA_W-1:0] head;
    logic              empty, full;
    logic              wdata_unused;

    assign sel      = decode_port(io_addr, DATA_PORT, STAT_PORT);
    assign op.pop   = io_rd && sel.sel_data;
    assign op.flush = io_wr && sel.sel_stat;
    assign wdata_unused = ^io_wdata;

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (sel.sel_data && !empty) begin
                io_rdata = head;
            end else if (sel.sel_stat) begin
                io_rdata = DATA_W'(!empty);
            end
        end
    end

    adc_rate_tick #(.RATE_W(RATE_W)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .reload_val (rate_div),
        .tick       (tick)
    );

    adc_conv_ctrl #(.DATA_W(DATA_W)) u_conv (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .fifo_full  (full),
        .cnv_done   (cnv_done),
        .cnv_data   (cnv_data),
        .cnv_cs     (cnv_cs),
        .cnv_rdmode (cnv_rdmode),
        .cnv_start  (cnv_start),
        .push       (push),
        .push_data  (push_data)
    );

    adc_sample_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (op.flush),
        .push      (push),
        .push_data (push_data),
        .pop       (op.pop),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!cnv_cs && !cnv_start && empty));

    // R8
    status_val_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && sel.sel_stat) |-> (io_rdata[DATA_W-1:1] == '0));

endmodule

// File: tb/adc_capture_fifo_tb.sv
module adc_capture_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rate_div = 16'd4;
    logic [15:0] io_addr = 16'h0000;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        cnv_cs, cnv_rdmode, cnv_start;
    logic        cnv_done;
    logic [7:0]  cnv_data;

    logic        man_done = 1'b0;
    logic [7:0]  man_data = 8'h00;
    logic        auto_en = 1'b0;
    logic        auto_done = 1'b0;
    logic [7:0]  auto_data = 8'h00;
    logic [7:0]  auto_val = 8'h00;

    int cyc = 0, total = 0, bad = 0;
    int nstart = 0, last1 = 0, last2 = 0;

    localparam logic [15:0] DPORT = 16'h04E7;
    localparam logic [15:0] SPORT = 16'h04E8;

    // rate, sample
    localparam logic [23:0] VEC [5] = '{
        {16'd3,  8'hA5}, {16'd5,  8'h3C}, {16'd9,  8'hFF},
        {16'd4,  8'h01}, {16'd14, 8'h80}
    };

    assign cnv_done = man_done | auto_done;
    assign cnv_data = man_done ? man_data : auto_data;

    adc_capture_fifo dut_i (
        .clk(clk), .rst(rst), .rate_div(rate_div),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .cnv_cs(cnv_cs), .cnv_rdmode(cnv_rdmode),
        .cnv_start(cnv_start), .cnv_done(cnv_done), .cnv_data(cnv_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cnv_start) begin
            nstart = nstart + 1;
            last2  = last1;
            last1  = cyc;
        end
        if (auto_en && cnv_cs && !auto_done) begin
            auto_done = 1'b1;
            auto_data = auto_val;
            auto_val  = auto_val + 8'd1;
        end else begin
            auto_done = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 v = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wr = 1'b1; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic wait_cs();
        while (!cnv_cs) @(negedge clk);
    endtask

    task automatic finish_conv(input logic [7:0] v);
        @(negedge clk);
        wait_cs();
        man_done = 1'b1; man_data = v;
        @(negedge clk);
        man_done = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        int s0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 cs", {31'd0, cnv_cs}, 32'd0);
        chk("R1 start", {31'd0, cnv_start}, 32'd0);
        rst = 1'b0;
        host_rd(SPORT, v); chk("R1 status", {24'd0, v}, 32'd0);
        host_rd(DPORT, v); chk("R7 empty read", {24'd0, v}, 32'd0);

        // R3: start strobe with chip-select and read mode
        while (!cnv_start) @(negedge clk);
        chk("R3 cs with start", {31'd0, cnv_cs}, 32'd1);
        chk("R3 rdmode with start", {31'd0, cnv_rdmode}, 32'd1);
        @(negedge clk);
        chk("R3 start one cycle", {31'd0, cnv_start}, 32'd0);
        chk("R3 cs held", {31'd0, cnv_cs}, 32'd1);

        // R5: ticks while outstanding are ignored
        s0 = nstart;
        repeat (25) @(negedge clk);
        chk("R5 no extra start", nstart - s0, 32'd0);
        chk("R5 cs still high", {31'd0, cnv_cs}, 32'd1);

        // R4: completion pushes and releases
        man_done = 1'b1; man_data = 8'h5A;
        @(negedge clk);
        man_done = 1'b0;
        chk("R4 cs released", {31'd0, cnv_cs}, 32'd0);
        // R11: done while idle
        man_done = 1'b1; man_data = 8'hEE;
        @(negedge clk);
        man_done = 1'b0;
        host_rd(SPORT, v); chk("R4 status after push", {24'd0, v}, 32'd1);
        host_rd(DPORT, v); chk("R4 pushed byte", {24'd0, v}, 32'h5A);
        host_rd(SPORT, v); chk("R11 idle done ignored", {24'd0, v}, 32'd0);

        // R7: order
        finish_conv(8'h11); finish_conv(8'h22); finish_conv(8'h33);
        // R12: write to data port and other addresses ignored
        host_wr(DPORT, 8'h00);
        host_wr(16'h04E9, 8'hFF);
        host_rd(16'h04E9, v); chk("R12 other read", {24'd0, v}, 32'd0);
        host_rd(DPORT, v); chk("R7 order 1", {24'd0, v}, 32'h11);
        host_rd(DPORT, v); chk("R7 order 2", {24'd0, v}, 32'h22);
        host_rd(DPORT, v); chk("R7 order 3", {24'd0, v}, 32'h33);
        host_rd(DPORT, v); chk("R7 empty zero", {24'd0, v}, 32'd0);
        host_rd(SPORT, v); chk("R8 empty status", {24'd0, v}, 32'd0);

        // R9: flush with arbitrary data
        finish_conv(8'h44); finish_conv(8'h55);
        host_rd(SPORT, v); chk("R8 status nonempty", {24'd0, v}, 32'd1);
        host_wr(SPORT, 8'hC3);
        host_rd(SPORT, v); chk("R9 flushed", {24'd0, v}, 32'd0);
        host_rd(DPORT, v); chk("R9 no data", {24'd0, v}, 32'd0);

        // R10: pop and push in the same cycle
        finish_conv(8'h66);
        @(negedge clk);
        wait_cs();
        man_done = 1'b1; man_data = 8'h77;
        io_addr = DPORT; io_rd = 1'b1;
        #1 v = io_rdata;
        chk("R10 popped old head", {24'd0, v}, 32'h66);
        @(negedge clk);
        man_done = 1'b0; io_rd = 1'b0;
        host_rd(SPORT, v); chk("R10 pushed held", {24'd0, v}, 32'd1);
        host_rd(DPORT, v); chk("R10 pushed byte", {24'd0, v}, 32'h77);
        host_rd(SPORT, v); chk("R10 now empty", {24'd0, v}, 32'd0);

        // R2: vector table of rates and samples
        for (int i = 0; i < 5; i++) begin
            rate_div = VEC[i][23:8];
            @(negedge clk);
            wait_cs();
            host_wr(SPORT, 8'h00);
            auto_val = VEC[i][7:0];
            auto_en = 1'b1;
            s0 = nstart;
            while (nstart < s0 + 3) @(negedge clk);
            auto_en = 1'b0;
            chk($sformatf("R2 period rate=%0d", VEC[i][23:8]),
                last1 - last2, {16'd0, VEC[i][23:8]} + 32'd1);
            repeat (3) @(negedge clk);
            host_rd(DPORT, v); chk("R7 first sample", {24'd0, v}, {24'd0, VEC[i][7:0]});
            host_wr(SPORT, 8'h00);
            host_rd(SPORT, v); chk("R9 flush after vector", {24'd0, v}, 32'd0);
        end

        // R6: fill to capacity, starts stop, then resume
        rate_div = 16'd3;
        @(negedge clk);
        wait_cs();
        host_wr(SPORT, 8'h00);
        auto_val = 8'h00;
        auto_en = 1'b1;
        repeat (64 * 4 + 60) @(negedge clk);
        s0 = nstart;
        repeat (30) @(negedge clk);
        chk("R6 no start when full", nstart - s0, 32'd0);
        chk("R6 cs low when full", {31'd0, cnv_cs}, 32'd0);
        auto_en = 1'b0;
        host_rd(SPORT, v); chk("R6 status full", {24'd0, v}, 32'd1);
        for (int k = 0; k < 64; k++) begin
            host_rd(DPORT, v);
            if (k == 0 || k == 63) chk("R6 full contents", {24'd0, v}, k);
            else if (v !== 8'(k)) chk("R6 full contents", {24'd0, v}, k);
        end
        host_rd(DPORT, v); chk("R6 drained", {24'd0, v}, 32'd0);
        repeat (6) @(negedge clk);
        chk("R6 starts resume", {31'd0, cnv_cs}, 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule